// File: doc/BRIEF.md
# Signature Table Lookup Walker

This block locates the reference signature record of a basic block inside a hash table that sits in main memory. A requester presents the block's start address together with its computed hash. The walker picks the table of the loaded module whose code range holds that address, computes the address of a bucket in that table and reads the record there. When the record's hash and block address both equal the request, the record is returned. Otherwise the walker follows the record's link to the next overflow record. A link of zero ends the chain with a not-found result.

A small register file holds one code range per module, given as a lowest and a highest address, along with that module's table base and bucket count. A lookup whose address lies outside every valid range is rejected at once. A chain that runs too long is cut off with a fault, so a damaged table cannot stall the requester forever. Only one lookup is in progress at a time. The memory side is a plain read port: a single-cycle request pulse, followed by a data pulse any number of cycles later.

Top module: `sigWalker`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0 and memReqValid is 0, and every range slot is invalid, so any lookup returns status 2 (no table) without a memory read.
- R2: A slot covers addresses from its low bound to its high bound, both bounds included. When several valid slots cover an address, the slot with the lowest index supplies the table.
- R3: A lookup whose address no valid slot covers answers with status 2 in the cycle after acceptance and issues no memory read.
- R4: The first read goes to tableBase + (((reqAddr XOR reqHash) AND (2^bucketBits - 1)) * 16). A record is 96 bits: bits [31:0] hash, bits [63:32] block address, bits [95:64] next-record address.
- R5: A record whose hash and block address both equal the request ends the walk with status 0. rspEntry carries the record and rspEntryAddr carries the address it was read from. Equal hashes with different block addresses do not match.
- R6: On a mismatch the walker reads the record at the next-record address. A mismatching record whose next-record address is zero ends the walk with status 1 (not found).
- R7: A walk reads at most 16 records. A 16th record that mismatches and has a nonzero link ends the walk with status 3 (chain fault).
- R8: reqReady is low from the acceptance edge until the cycle after the single-cycle rspValid pulse. memReqValid is a single-cycle pulse, and a new read is issued only after the previous data has returned, whatever the memory latency.
- R9: A slot write taken at the same edge as a request acceptance does not affect that lookup. Lookups accepted later use the new slot contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Slot write strobe |
| cfgSlot | input | 2 | Slot index to write |
| cfgCodeLo | input | 32 | Lowest code address of the module |
| cfgCodeHi | input | 32 | Highest code address of the module |
| cfgTableBase | input | 32 | Byte address of the module's table |
| cfgBucketBits | input | 5 | log2 of the bucket count |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Walker idle, request accepted |
| reqAddr | input | 32 | Basic block start address |
| reqHash | input | 32 | Basic block hash |
| memReqValid | output | 1 | Memory read pulse |
| memReqAddr | output | 32 | Memory read address |
| memRspValid | input | 1 | Memory data valid |
| memRspData | input | 96 | Record read from memory |
| rspValid | output | 1 | Result pulse |
| rspStatus | output | 2 | 0 hit, 1 not found, 2 no table, 3 chain fault |
| rspEntry | output | 96 | Matching record on a hit |
| rspEntryAddr | output | 32 | Address of the matching record |

## Verification
Two functions can fall in the same cycle: a slot write and the acceptance of a lookup that depends on that slot. The bench provokes this by raising cfgWe and reqValid on the same idle cycle. The write changes the table base of the slot that covers the request. The bench then judges the outcome from the result: the lookup must hit at the record address from the old table base, and a repeat of the same lookup must read from the new table base and miss there.

// File: rtl/sigWalkPkg.sv
package sigWalkPkg;

  typedef enum logic [1:0] {
    ST_HIT     = 2'd0,
    ST_MISS    = 2'd1,
    ST_NOTABLE = 2'd2,
    ST_LOOP    = 2'd3
  } walkStatusE;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // latch key, load bucket address, clear step count
    logic issue;    // a read goes out this cycle
    logic capture;  // store returned record
    logic follow;   // move to next-record address
  } walkStrobesT;

endpackage

// File: rtl/sigTableRegs.sv
module sigTableRegs #(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 4,
  parameter int BKT_W     = 5,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] slot,
  input  logic [ADDR_W-1:0] codeLo,
  input  logic [ADDR_W-1:0] codeHi,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [BKT_W-1:0]  bucketBits,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              anyHit,
  output logic [ADDR_W-1:0] selBase,
  output logic [BKT_W-1:0]  selBits
);

  logic [ADDR_W-1:0] loReg   [NUM_SLOTS];
  logic [ADDR_W-1:0] hiReg   [NUM_SLOTS];
  logic [ADDR_W-1:0] baseReg [NUM_SLOTS];
  logic [BKT_W-1:0]  bitsReg [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotValid;
  logic [NUM_SLOTS-1:0] inRange;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (rst) begin
        slotValid[g] <= 1'b0;
        loReg[g]     <= '0;
        hiReg[g]     <= '0;
        baseReg[g]   <= '0;
        bitsReg[g]   <= '0;
      end else if (we && slot == SLOT_W'(g)) begin
        slotValid[g] <= 1'b1;
        loReg[g]     <= codeLo;
        hiReg[g]     <= codeHi;
        baseReg[g]   <= tableBase;
        bitsReg[g]   <= bucketBits;
      end
    end

    assign inRange[g] = slotValid[g] &&
                        (lookupAddr >= loReg[g]) &&
                        (lookupAddr <= hiReg[g]);
  end

  // lowest index wins: scan from the top so lower slots overwrite
  always_comb begin
    selBase = '0;
    selBits = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (inRange[i]) begin
        selBase = baseReg[i];
        selBits = bitsReg[i];
      end
    end
  end

  assign anyHit = |inRange;

  AST_NO_SLOTS_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (slotValid == '0)) else $error("slots valid after reset"); // R1

endmodule

// File: rtl/sigWalkDatapath.sv
module sigWalkDatapath
  import sigWalkPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int HASH_W      = 32,
  parameter int NUM_SLOTS   = 4,
  parameter int BKT_W       = 5,
  parameter int MAX_STEPS   = 16,
  parameter int ENTRY_SHIFT = 4,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int ENTRY_W    = HASH_W + 2 * ADDR_W,
  localparam int STEP_W     = $clog2(MAX_STEPS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  walkStrobesT        strobes,
  input  logic               cfgWe,
  input  logic [SLOT_W-1:0]  cfgSlot,
  input  logic [ADDR_W-1:0]  cfgCodeLo,
  input  logic [ADDR_W-1:0]  cfgCodeHi,
  input  logic [ADDR_W-1:0]  cfgTableBase,
  input  logic [BKT_W-1:0]   cfgBucketBits,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [HASH_W-1:0]  reqHash,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               tableHit,
  output logic               entryMatch,
  output logic               nextZero,
  output logic               stepsAtMax,
  output logic [ADDR_W-1:0]  curAddr,
  output logic [ENTRY_W-1:0] entry
);

  logic [ADDR_W-1:0] selBase;
  logic [BKT_W-1:0]  selBits;
  logic [ADDR_W-1:0] bucketMask;
  logic [ADDR_W-1:0] bucketIdx;
  logic [ADDR_W-1:0] bucketAddr;
  logic [ADDR_W-1:0] keyAddr;
  logic [HASH_W-1:0] keyHash;
  logic [STEP_W-1:0] stepCnt;

  logic [HASH_W-1:0] entHash;
  logic [ADDR_W-1:0] entBlk;
  logic [ADDR_W-1:0] entNext;

  sigTableRegs #(
    .ADDR_W   (ADDR_W),
    .NUM_SLOTS(NUM_SLOTS),
    .BKT_W    (BKT_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (cfgWe),
    .slot      (cfgSlot),
    .codeLo    (cfgCodeLo),
    .codeHi    (cfgCodeHi),
    .tableBase (cfgTableBase),
    .bucketBits(cfgBucketBits),
    .lookupAddr(reqAddr),
    .anyHit    (tableHit),
    .selBase   (selBase),
    .selBits   (selBits)
  );

  // bucket address from the selected slot and the lookup key
  always_comb begin
    bucketMask = (ADDR_W'(1) << selBits) - ADDR_W'(1);
    bucketIdx  = (reqAddr ^ ADDR_W'(reqHash)) & bucketMask;
    bucketAddr = selBase + (bucketIdx << ENTRY_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      keyAddr <= '0;
      keyHash <= '0;
      curAddr <= '0;
      stepCnt <= '0;
      entry   <= '0;
    end else begin
      if (strobes.accept) begin
        keyAddr <= reqAddr;
        keyHash <= reqHash;
        curAddr <= bucketAddr;
        stepCnt <= '0;
      end
      if (strobes.issue)   stepCnt <= stepCnt + STEP_W'(1);
      if (strobes.capture) entry   <= memRspData;
      if (strobes.follow)  curAddr <= entNext;
    end
  end

  assign entHash = entry[HASH_W-1:0];
  assign entBlk  = entry[HASH_W +: ADDR_W];
  assign entNext = entry[HASH_W + ADDR_W +: ADDR_W];

  assign entryMatch = (entHash == keyHash) && (entBlk == keyAddr);
  assign nextZero   = (entNext == '0);
  assign stepsAtMax = (stepCnt == STEP_W'(MAX_STEPS));

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    stepCnt <= STEP_W'(MAX_STEPS)) else $error("step count beyond limit"); // R7

  AST_NO_ISSUE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    strobes.issue |-> !stepsAtMax) else $error("read issued past limit"); // R7

endmodule

// File: rtl/sigWalkCtrl.sv
module sigWalkCtrl
  import sigWalkPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        memRspValid,
  output logic        memReqValid,
  output logic        rspValid,
  output logic [1:0]  rspStatus,
  input  logic        tableHit,
  input  logic        entryMatch,
  input  logic        nextZero,
  input  logic        stepsAtMax,
  output walkStrobesT strobes
);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_CHECK, S_RESP
  } walkStateE;

  walkStateE  state, stateNext;
  walkStatusE stat, statNext;

  always_comb begin
    stateNext = state;
    statNext  = stat;
    strobes   = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobes.accept = 1'b1;
          if (tableHit) begin
            stateNext = S_ISSUE;
          end else begin
            statNext  = ST_NOTABLE;
            stateNext = S_RESP;
          end
        end
      end
      S_ISSUE: begin
        strobes.issue = 1'b1;
        stateNext     = S_WAIT;
      end
      S_WAIT: begin
        if (memRspValid) begin
          strobes.capture = 1'b1;
          stateNext       = S_CHECK;
        end
      end
      S_CHECK: begin
        if (entryMatch) begin
          statNext  = ST_HIT;
          stateNext = S_RESP;
        end else if (nextZero) begin
          statNext  = ST_MISS;
          stateNext = S_RESP;
        end else if (stepsAtMax) begin
          statNext  = ST_LOOP;
          stateNext = S_RESP;
        end else begin
          strobes.follow = 1'b1;
          stateNext      = S_ISSUE;
        end
      end
      S_RESP: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      stat  <= ST_HIT;
    end else begin
      state <= stateNext;
      stat  <= statNext;
    end
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign rspValid    = (state == S_RESP);
  assign rspStatus   = stat;

  AST_ONE_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    memReqValid |=> !memReqValid) else $error("read pulse too long"); // R8

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> (!rspValid && reqReady)) else $error("result pulse malformed"); // R8

  AST_NOTABLE_FAST: assert property (@(posedge clk) disable iff (rst)
    (rspValid && stat == ST_NOTABLE) |-> $past(reqValid && reqReady))
    else $error("no-table result late"); // R3

  AST_HIT_MATCHES: assert property (@(posedge clk) disable iff (rst)
    (rspValid && stat == ST_HIT) |-> entryMatch) else $error("hit without match"); // R5

  AST_LOOP_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (rspValid && stat == ST_LOOP) |-> stepsAtMax) else $error("fault before limit"); // R7

endmodule

// File: rtl/sigWalker.sv
module sigWalker
  import sigWalkPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int HASH_W      = 32,
  parameter int NUM_SLOTS   = 4,
  parameter int BKT_W       = 5,
  parameter int MAX_STEPS   = 16,
  parameter int ENTRY_SHIFT = 4,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int ENTRY_W    = HASH_W + 2 * ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic [SLOT_W-1:0]  cfgSlot,
  input  logic [ADDR_W-1:0]  cfgCodeLo,
  input  logic [ADDR_W-1:0]  cfgCodeHi,
  input  logic [ADDR_W-1:0]  cfgTableBase,
  input  logic [BKT_W-1:0]   cfgBucketBits,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [HASH_W-1:0]  reqHash,
  output logic               memReqValid,
  output logic [ADDR_W-1:0]  memReqAddr,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               rspValid,
  output logic [1:0]         rspStatus,
  output logic [ENTRY_W-1:0] rspEntry,
  output logic [ADDR_W-1:0]  rspEntryAddr
);

  walkStrobesT strobes;
  logic tableHit, entryMatch, nextZero, stepsAtMax;
  logic [ADDR_W-1:0] curAddr;

  sigWalkCtrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .memRspValid(memRspValid),
    .memReqValid(memReqValid),
    .rspValid   (rspValid),
    .rspStatus  (rspStatus),
    .tableHit   (tableHit),
    .entryMatch (entryMatch),
    .nextZero   (nextZero),
    .stepsAtMax (stepsAtMax),
    .strobes    (strobes)
  );

  sigWalkDatapath #(
    .ADDR_W     (ADDR_W),
    .HASH_W     (HASH_W),
    .NUM_SLOTS  (NUM_SLOTS),
    .BKT_W      (BKT_W),
    .MAX_STEPS  (MAX_STEPS),
    .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .cfgWe        (cfgWe),
    .cfgSlot      (cfgSlot),
    .cfgCodeLo    (cfgCodeLo),
    .cfgCodeHi    (cfgCodeHi),
    .cfgTableBase (cfgTableBase),
    .cfgBucketBits(cfgBucketBits),
    .reqAddr      (reqAddr),
    .reqHash      (reqHash),
    .memRspData   (memRspData),
    .tableHit     (tableHit),
    .entryMatch   (entryMatch),
    .nextZero     (nextZero),
    .stepsAtMax   (stepsAtMax),
    .curAddr      (curAddr),
    .entry        (rspEntry)
  );

  assign memReqAddr   = curAddr;
  assign rspEntryAddr = curAddr;

endmodule

// File: tb/sigWalker_tb.sv
module sigWalker_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSlot = '0;
  logic [31:0] cfgCodeLo = '0, cfgCodeHi = '0, cfgTableBase = '0;
  logic [4:0]  cfgBucketBits = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0, reqHash = '0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [95:0] memRspData;
  logic        rspValid;
  logic [1:0]  rspStatus;
  logic [95:0] rspEntry;
  logic [31:0] rspEntryAddr;

  always #4 clk = ~clk; // 125 MHz

  sigWalker u_dut (.*);

  // memory model: one record per 16 bytes, latency 1..3 cycles
  logic [95:0] mem [256];
  logic [31:0] pendAddr;
  int          readCount;
  int          waitCnt;
  logic        busy;

  always @(posedge clk) begin
    if (rst) begin
      readCount   <= 0;
      busy        <= 1'b0;
      memRspValid <= 1'b0;
      memRspData  <= '0;
      waitCnt     <= 0;
    end else if (memReqValid) begin
      readCount   <= readCount + 1;
      pendAddr    <= memReqAddr;
      waitCnt     <= 1 + (readCount % 3);
      busy        <= 1'b1;
      memRspValid <= 1'b0;
    end else if (busy) begin
      if (waitCnt == 1) begin
        memRspValid <= 1'b1;
        memRspData  <= mem[pendAddr[11:4]];
        busy        <= 1'b0;
      end
      waitCnt <= waitCnt - 1;
    end else begin
      memRspValid <= 1'b0;
    end
  end

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] rec(input logic [31:0] nxt, input logic [31:0] blk, input logic [31:0] h);
    return {nxt, blk, h};
  endfunction

  task automatic cfgWrite(input logic [1:0] s, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [31:0] tb, input logic [4:0] b);
    @(negedge clk);
    cfgWe = 1'b1; cfgSlot = s; cfgCodeLo = lo; cfgCodeHi = hi; cfgTableBase = tb; cfgBucketBits = b;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // drives one lookup; any cfg signals already raised are cleared after acceptance
  task automatic lookup(input logic [31:0] a, input logic [31:0] h, input string tag,
                        output logic [1:0] st, output logic [31:0] ea,
                        output logic [95:0] en, output int reads);
    int r0;
    int guard;
    bit readyLeak;
    if (!cfgWe) @(negedge clk);
    r0 = readCount;
    reqValid = 1'b1; reqAddr = a; reqHash = h;
    @(negedge clk);
    reqValid = 1'b0; cfgWe = 1'b0;
    guard = 0; readyLeak = 1'b0;
    while (!rspValid && guard < 2000) begin
      if (reqReady) readyLeak = 1'b1;
      @(negedge clk);
      guard++;
    end
    check(guard < 2000, {tag, " watchdog"}, 96'(guard), 96'(0));
    check(!readyLeak && !reqReady, {"R8 ready low during walk ", tag}, 96'(readyLeak), 96'(0));
    st = rspStatus; ea = rspEntryAddr; en = rspEntry;
    reads = readCount - r0;
    @(negedge clk);
    check(reqReady && !rspValid, {"R8 single result pulse ", tag}, 96'({reqReady, rspValid}), 96'(2));
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] hash;
    logic [1:0]  st;
    logic [31:0] eaddr;
    logic [7:0]  reads;
  } vecT;

  // status: 0 hit, 1 not found, 2 no table, 3 chain fault
  localparam int NV = 12;
  localparam vecT VECS [NV] = '{
    '{32'h1000, 32'h1,  2'd0, 32'h110, 8'd1},   // R4 R5 direct bucket hit
    '{32'h1004, 32'h6,  2'd0, 32'h200, 8'd2},   // R6 hit after one link
    '{32'h1008, 32'h6,  2'd0, 32'h210, 8'd3},   // R5 same hash, tag tells apart
    '{32'h100C, 32'h6,  2'd1, 32'h0,   8'd3},   // R6 chain end, not found
    '{32'h3000, 32'h5,  2'd2, 32'h0,   8'd0},   // R3 outside every slot
    '{32'h8000, 32'h55, 2'd0, 32'h400, 8'd1},   // R4 single-bucket table
    '{32'h1000, 32'h0,  2'd1, 32'h0,   8'd1},   // R6 empty bucket
    '{32'hC000, 32'h99, 2'd3, 32'h0,   8'd16},  // R7 self loop
    '{32'hD000, 32'h77, 2'd0, 32'h9F0, 8'd16},  // R7 hit on 16th read
    '{32'hD004, 32'h77, 2'd1, 32'h0,   8'd16},  // R7 16-long chain ends
    '{32'h1FFF, 32'h0,  2'd1, 32'h0,   8'd1},   // R2 high bound included
    '{32'h0FFF, 32'h0,  2'd2, 32'h0,   8'd0}    // R2 R3 below low bound
  };

  initial begin
    logic [1:0]  st;
    logic [31:0] ea;
    logic [95:0] en;
    int          rd;

    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h11] = rec(32'h0,   32'h1000, 32'h1);
    mem[8'h12] = rec(32'h200, 32'h1234, 32'hAA);
    mem[8'h20] = rec(32'h210, 32'h1004, 32'h6);
    mem[8'h21] = rec(32'h0,   32'h1008, 32'h6);
    mem[8'h40] = rec(32'h0,   32'h8000, 32'h55);
    mem[8'h80] = rec(32'h800, 32'h0,    32'h11);
    for (int k = 0; k < 16; k++)
      mem[8'h90 + k] = rec((k == 15) ? 32'h0 : 32'h900 + 32'((k + 1) * 16),
                           (k == 15) ? 32'hD000 : 32'h0, 32'h77);

    repeat (3) @(negedge clk);
    // R1 reset state, sampled with reset still high
    check(reqReady && !rspValid && !memReqValid, "R1 outputs in reset",
          96'({reqReady, rspValid, memReqValid}), 96'(4));
    rst = 1'b0;
    @(negedge clk);
    check(reqReady && !rspValid && !memReqValid, "R1 outputs after reset",
          96'({reqReady, rspValid, memReqValid}), 96'(4));

    // R1 no slot valid yet
    lookup(32'h1000, 32'h1, "R1", st, ea, en, rd);
    check(st == 2'd2, "R1 status before config", 96'(st), 96'(2));
    check(rd == 0, "R1 no read before config", 96'(rd), 96'(0));

    cfgWrite(2'd0, 32'h1000, 32'h1FFF, 32'h100, 5'd2);
    cfgWrite(2'd1, 32'h8000, 32'h8FFF, 32'h400, 5'd0);
    cfgWrite(2'd2, 32'hC000, 32'hC0FF, 32'h800, 5'd0);
    cfgWrite(2'd3, 32'hD000, 32'hDFFF, 32'h900, 5'd0);

    for (int v = 0; v < NV; v++) begin
      lookup(VECS[v].addr, VECS[v].hash, $sformatf("vec%0d", v), st, ea, en, rd);
      check(st == VECS[v].st, $sformatf("R5 R6 R7 status vec%0d", v), 96'(st), 96'(VECS[v].st));
      check(rd == int'(VECS[v].reads), $sformatf("R4 R7 read count vec%0d", v), 96'(rd), 96'(VECS[v].reads));
      if (VECS[v].st == 2'd0) begin
        check(ea == VECS[v].eaddr, $sformatf("R5 record address vec%0d", v), 96'(ea), 96'(VECS[v].eaddr));
        check(en[31:0] == VECS[v].hash && en[63:32] == VECS[v].addr,
              $sformatf("R5 record content vec%0d", v), en, 96'({VECS[v].addr, VECS[v].hash}));
      end
    end

    // R2 overlap: slot 2 widened over slot 3 range, lowest index wins
    cfgWrite(2'd2, 32'hC000, 32'hDFFF, 32'h800, 5'd0);
    lookup(32'hD000, 32'h77, "R2", st, ea, en, rd);
    check(st == 2'd3, "R2 lower slot wins", 96'(st), 96'(3));
    check(rd == 16, "R2 reads in lower slot table", 96'(rd), 96'(16));

    // R9 write slot 0 to a new table in the same cycle as acceptance
    @(negedge clk);
    cfgWe = 1'b1; cfgSlot = 2'd0; cfgCodeLo = 32'h1000; cfgCodeHi = 32'h1FFF;
    cfgTableBase = 32'h400; cfgBucketBits = 5'd0;
    lookup(32'h1000, 32'h1, "R9 same edge", st, ea, en, rd);
    check(st == 2'd0 && ea == 32'h110, "R9 old table used", 96'({st, ea}), 96'({2'd0, 32'h110}));
    lookup(32'h1000, 32'h1, "R9 after", st, ea, en, rd);
    check(st == 2'd1 && rd == 1, "R9 new table used", 96'({st, 8'(rd)}), 96'({2'd1, 8'd1}));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule